// File: doc/BRIEF.md
# Interrupt enable/pending arbiter

This block keeps the enable, pending and active state of a configurable number of external interrupt lines and picks the line a core should service next. Each line has an 8-bit priority. Among the lines that are both pending and enabled, the lowest priority value wins. A tie goes to the lower line number. The winner is presented to the core as a valid flag, a line number and its priority.

Software reaches the state through a simple 32-bit register bus with address, write data, write strobe and read strobe. Read data is registered.

Enable and pending state can only be changed through separate set and clear views. In both, a 1 bit acts and a 0 bit is ignored. A trigger register pends a line by its number. Hardware pends a line on a rising edge of its request input. The core acknowledges the presented winner, which moves it from pending to active. It later reports completion of a line by number, which clears that line's active bit. A status word gives the winning vector number, with external lines numbered from 16, together with the running (active) vector.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, every enable, pending and active bit and every priority byte is 0, `irq_valid` is 0 and `bus_rdata` is 0.
- R2: A write to 0x100+4w sets enable bits of lines 32w..32w+31 where the data bit is 1. A write to 0x140+4w clears them the same way. A 0 bit has no effect, and both addresses read back the current enable word.
- R3: Writes to 0x180+4w (set) and 0x1C0+4w (clear) act on pending bits with the same write-one rules, and both addresses read back the pending word. A pending clear wins over any pending set that lands in the same cycle.
- R4: A 0-to-1 change on `irq_req[i]` while line i is enabled sets pending[i] on the clock edge that first samples the high level. A level held high does not pend again, and an edge on a disabled line is ignored.
- R5: The priority of line 4k+i is byte i (bits 8i+7..8i) of the read/write word at 0x300+4k.
- R6: `irq_valid` is 1 exactly when some line is pending and enabled. `irq_id` and `irq_prio` then give the line with the lowest priority value, and the lowest line number among equal values.
- R7: A pending line whose enable is 0 takes no part in arbitration and keeps its pending bit.
- R8: `irq_ack` while `irq_valid` is 1 clears the winner's pending bit and sets its active bit on that edge. The active word at 0x200+4w is read-only, and writes to it are ignored.
- R9: `irq_done` with `irq_done_id` below the line count clears that line's active bit.
- R10: Writing n to bits 8..0 of 0x008 sets pending[n] when n is below the line count. A larger n changes nothing.
- R11: Bits 4..0 of 0x000 read (line count / 32) - 1.
- R12: The status word at 0x004 has these fields. Bits 9..0 hold the winner's line+16, or 0 when there is no winner. Bit 10 is `irq_valid`. Bits 20..12 hold line+16 of the highest-priority active line (lowest number on ties), or 0 when none is active. Bit 21 is 1 when at most one line is active. Bits 31..24 hold that active line's priority, or 0.
- R13: Read data appears on `bus_rdata` in the cycle after `bus_rd`. An unmapped address, a word index beyond the line count or a misaligned address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Registered read data |
| irq_req | input | NUM_LINES | Raw interrupt request levels |
| irq_ack | input | 1 | Core accepts the presented winner |
| irq_done | input | 1 | Core finished servicing a line |
| irq_done_id | input | 9 | Line number for `irq_done` |
| irq_valid | output | 1 | A pending, enabled line exists |
| irq_id | output | 9 | Winning line number |
| irq_prio | output | 8 | Priority of the winning line |

## Verification
The assertions assume that `irq_req` is synchronous to `clk` and that bus strobes last one cycle. They also assume that `irq_ack` is only meaningful while `irq_valid` is high, and that `irq_done_id` names a line the core previously acknowledged. The bench drives every input on the falling edge, pulses each strobe for exactly one cycle, and raises `irq_ack` only after it has checked that a winner is presented. The sweeps use a 64-line configuration, in which every line's enable bit and every priority byte can be touched.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned PRIO_W   = 8;
  localparam int unsigned ID_W     = 9;
  localparam int unsigned BUS_AW   = 12;
  localparam int unsigned VEC_BASE = 16;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_TYPE, SEL_STAT, SEL_TRIG,
    SEL_ENSET, SEL_ENCLR, SEL_PDSET, SEL_PDCLR,
    SEL_ACT, SEL_PRIO
  } sel_kind_e;

  typedef struct packed {
    sel_kind_e  kind;
    logic [5:0] idx;
  } reg_sel_t;

  typedef struct packed {
    logic              valid;
    logic [ID_W-1:0]   id;
    logic [PRIO_W-1:0] prio;
  } winner_t;
endpackage

// File: rtl/irq_addr_dec.sv
module irq_addr_dec
  import irq_pkg::*;
#(
  parameter int unsigned NUM_LINES = 64
) (
  input  logic [BUS_AW-1:0] addr,
  output reg_sel_t          sel
);
  localparam int unsigned NUM_WORDS  = NUM_LINES / 32;
  localparam int unsigned PRIO_WORDS = NUM_LINES / 4;
  localparam logic [4:0]  NW_L       = 5'(NUM_WORDS);
  localparam logic [6:0]  PW_L       = 7'(PRIO_WORDS);

  logic word_ok;
  logic prio_ok;

  always_comb begin
    word_ok  = ({1'b0, addr[5:2]} < NW_L);
    prio_ok  = ({1'b0, addr[7:2]} < PW_L);
    sel.kind = SEL_NONE;
    sel.idx  = addr[7:2];
    if (addr[1:0] == 2'b00) begin
      unique case (addr[11:8])
        4'h0: begin
          unique case (addr[7:2])
            6'd0:    sel.kind = SEL_TYPE;
            6'd1:    sel.kind = SEL_STAT;
            6'd2:    sel.kind = SEL_TRIG;
            default: sel.kind = SEL_NONE;
          endcase
        end
        4'h1: begin
          sel.idx = {2'b00, addr[5:2]};
          if (word_ok) begin
            unique case (addr[7:6])
              2'd0: sel.kind = SEL_ENSET;
              2'd1: sel.kind = SEL_ENCLR;
              2'd2: sel.kind = SEL_PDSET;
              2'd3: sel.kind = SEL_PDCLR;
            endcase
          end
        end
        4'h2: begin
          sel.idx = {2'b00, addr[5:2]};
          if (word_ok && addr[7:6] == 2'b00) sel.kind = SEL_ACT;
        end
        4'h3: begin
          if (prio_ok) sel.kind = SEL_PRIO;
        end
        default: sel.kind = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int unsigned NUM_LINES = 64
) (
  input  logic [NUM_LINES-1:0]        cand,
  input  logic [NUM_LINES*PRIO_W-1:0] prio_flat,
  output winner_t                     win
);
  always_comb begin
    win = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (cand[i] && (!win.valid || prio_flat[i*PRIO_W +: PRIO_W] < win.prio)) begin
        win.valid = 1'b1;
        win.id    = ID_W'(i);
        win.prio  = prio_flat[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/irq_state_bank.sv
module irq_state_bank
  import irq_pkg::*;
#(
  parameter int unsigned NUM_LINES = 64
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_LINES-1:0]        en_set,
  input  logic [NUM_LINES-1:0]        en_clr,
  input  logic [NUM_LINES-1:0]        pd_set,
  input  logic [NUM_LINES-1:0]        pd_clr,
  input  logic [NUM_LINES-1:0]        req,
  input  logic                        trig_valid,
  input  logic [ID_W-1:0]             trig_id,
  input  logic                        ack,
  input  winner_t                     win,
  input  logic                        done,
  input  logic [ID_W-1:0]             done_id,
  input  logic [NUM_LINES/4-1:0]      prio_word_we,
  input  logic [31:0]                 wdata,
  output logic [NUM_LINES-1:0]        en,
  output logic [NUM_LINES-1:0]        pend,
  output logic [NUM_LINES-1:0]        act,
  output logic [NUM_LINES*PRIO_W-1:0] prio_flat
);
  localparam int unsigned PRIO_WORDS = NUM_LINES / 4;
  localparam logic [ID_W:0] NL_L     = (ID_W+1)'(NUM_LINES);

  logic [NUM_LINES-1:0] en_q, en_d;
  logic [NUM_LINES-1:0] pend_q, pend_d;
  logic [NUM_LINES-1:0] act_q, act_d;
  logic [NUM_LINES-1:0] req_q;
  logic [NUM_LINES-1:0] rise;
  logic [NUM_LINES-1:0] trig_mask, ack_mask, done_mask;
  logic                 ack_ok, done_ok;

  always_comb begin
    ack_ok  = ack && win.valid;
    done_ok = done && ({1'b0, done_id} < NL_L);
    for (int i = 0; i < NUM_LINES; i++) begin
      trig_mask[i] = trig_valid && (trig_id == ID_W'(i));
      ack_mask[i]  = ack_ok && (win.id == ID_W'(i));
      done_mask[i] = done_ok && (done_id == ID_W'(i));
    end
    rise   = req & ~req_q;
    en_d   = (en_q | en_set) & ~en_clr;
    pend_d = (pend_q | pd_set | (rise & en_q) | trig_mask) & ~pd_clr & ~ack_mask;
    act_d  = (act_q & ~done_mask) | ack_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      pend_q <= '0;
      act_q  <= '0;
      req_q  <= '0;
    end else begin
      en_q   <= en_d;
      pend_q <= pend_d;
      act_q  <= act_d;
      req_q  <= req;
    end
  end

  for (genvar k = 0; k < PRIO_WORDS; k++) begin : g_prio_word
    for (genvar b = 0; b < 4; b++) begin : g_prio_byte
      logic [PRIO_W-1:0] p_q, p_d;
      always_comb begin
        p_d = p_q;
        if (prio_word_we[k]) p_d = wdata[b*8 +: 8];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
      end
      assign prio_flat[(4*k+b)*PRIO_W +: PRIO_W] = p_q;
    end
  end

  assign en   = en_q;
  assign pend = pend_q;
  assign act  = act_q;

  // R2: a set bit without a matching clear leaves the enable bit at 1
  p_enable_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|(en_set & ~en_clr)) |=> ((en_q & $past(en_set & ~en_clr)) == $past(en_set & ~en_clr)));

  // R3: a clear write leaves every addressed pending bit at 0
  p_pend_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|pd_clr) |=> ((pend_q & $past(pd_clr)) == '0));

  // R8: the acknowledged winner becomes active and stops pending
  p_ack_moves_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && win.valid) |=> (act_q[$past(win.id)] && !pend_q[$past(win.id)]));

  // R9: completion clears active unless the same line is acknowledged again
  p_done_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_ok && !(ack_ok && win.id == done_id)) |=> !act_q[$past(done_id)]);
endmodule

// File: rtl/irq_regif.sv
module irq_regif
  import irq_pkg::*;
#(
  parameter int unsigned NUM_LINES = 64
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [BUS_AW-1:0]           addr,
  input  logic [31:0]                 wdata,
  input  logic                        wr,
  input  logic                        rd,
  output logic [31:0]                 rdata,
  input  logic [NUM_LINES-1:0]        en,
  input  logic [NUM_LINES-1:0]        pend,
  input  logic [NUM_LINES-1:0]        act,
  input  logic [NUM_LINES*PRIO_W-1:0] prio_flat,
  input  logic                        pend_valid,
  input  logic [ID_W-1:0]             pend_id,
  input  logic                        act_valid,
  input  logic [ID_W-1:0]             act_id,
  input  logic [PRIO_W-1:0]           act_prio,
  output logic [NUM_LINES-1:0]        en_set,
  output logic [NUM_LINES-1:0]        en_clr,
  output logic [NUM_LINES-1:0]        pd_set,
  output logic [NUM_LINES-1:0]        pd_clr,
  output logic                        trig_valid,
  output logic [ID_W-1:0]             trig_id,
  output logic [NUM_LINES/4-1:0]      prio_word_we
);
  localparam int unsigned NUM_WORDS  = NUM_LINES / 32;
  localparam int unsigned PRIO_WORDS = NUM_LINES / 4;
  localparam logic [ID_W:0] NL_L     = (ID_W+1)'(NUM_LINES);
  localparam logic [NUM_LINES-1:0] ONE_L = {{(NUM_LINES-1){1'b0}}, 1'b1};

  reg_sel_t    sel;
  logic [31:0] rd_mux, rdata_d, rdata_q, stat_word;
  logic        single_act;

  irq_addr_dec #(.NUM_LINES(NUM_LINES)) u_dec (
    .addr (addr),
    .sel  (sel)
  );

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_mask_word
    logic hit;
    assign hit = wr && (sel.idx == 6'(w));
    assign en_set[w*32 +: 32] = (hit && sel.kind == SEL_ENSET) ? wdata : 32'h0;
    assign en_clr[w*32 +: 32] = (hit && sel.kind == SEL_ENCLR) ? wdata : 32'h0;
    assign pd_set[w*32 +: 32] = (hit && sel.kind == SEL_PDSET) ? wdata : 32'h0;
    assign pd_clr[w*32 +: 32] = (hit && sel.kind == SEL_PDCLR) ? wdata : 32'h0;
  end

  for (genvar k = 0; k < PRIO_WORDS; k++) begin : g_prio_we
    assign prio_word_we[k] = wr && sel.kind == SEL_PRIO && (sel.idx == 6'(k));
  end

  assign trig_id    = wdata[ID_W-1:0];
  assign trig_valid = wr && sel.kind == SEL_TRIG && ({1'b0, wdata[ID_W-1:0]} < NL_L);

  always_comb begin
    single_act          = ((act & (act - ONE_L)) == '0);
    stat_word           = '0;
    stat_word[9:0]      = pend_valid ? (10'(pend_id) + 10'(VEC_BASE)) : 10'd0;
    stat_word[10]       = pend_valid;
    stat_word[20:12]    = act_valid ? (act_id + ID_W'(VEC_BASE)) : '0;
    stat_word[21]       = single_act;
    stat_word[31:24]    = act_valid ? act_prio : '0;
  end

  always_comb begin
    rd_mux = '0;
    unique case (sel.kind)
      SEL_TYPE: rd_mux[4:0] = 5'(NUM_WORDS - 1);
      SEL_STAT: rd_mux = stat_word;
      SEL_ENSET, SEL_ENCLR: begin
        for (int w = 0; w < NUM_WORDS; w++)
          if (sel.idx == 6'(w)) rd_mux = en[w*32 +: 32];
      end
      SEL_PDSET, SEL_PDCLR: begin
        for (int w = 0; w < NUM_WORDS; w++)
          if (sel.idx == 6'(w)) rd_mux = pend[w*32 +: 32];
      end
      SEL_ACT: begin
        for (int w = 0; w < NUM_WORDS; w++)
          if (sel.idx == 6'(w)) rd_mux = act[w*32 +: 32];
      end
      SEL_PRIO: begin
        for (int k = 0; k < PRIO_WORDS; k++)
          if (sel.idx == 6'(k)) rd_mux = prio_flat[k*32 +: 32];
      end
      default: rd_mux = '0;
    endcase
    rdata_d = rd ? rd_mux : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;

  // R13: an access that decodes to nothing returns zero next cycle
  p_rd_unmapped_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && sel.kind == SEL_NONE) |=> (rdata_q == '0));
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned NUM_LINES = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [11:0]          bus_addr,
  input  logic [31:0]          bus_wdata,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  output logic [31:0]          bus_rdata,
  input  logic [NUM_LINES-1:0] irq_req,
  input  logic                 irq_ack,
  input  logic                 irq_done,
  input  logic [8:0]           irq_done_id,
  output logic                 irq_valid,
  output logic [8:0]           irq_id,
  output logic [7:0]           irq_prio
);
  logic [1:0]                  rst_sync_q, rst_sync_d;
  logic                        rst_core_n;
  logic [NUM_LINES-1:0]        en, pend, act;
  logic [NUM_LINES-1:0]        en_set, en_clr, pd_set, pd_clr;
  logic [NUM_LINES*PRIO_W-1:0] prio_flat;
  logic [NUM_LINES/4-1:0]      prio_word_we;
  logic                        trig_valid;
  logic [ID_W-1:0]             trig_id;
  winner_t                     pwin, awin;

  assign rst_sync_d = {rst_sync_q[0], 1'b1};
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= rst_sync_d;
  end
  assign rst_core_n = rst_sync_q[1];

  irq_regif #(.NUM_LINES(NUM_LINES)) u_regif (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .addr         (bus_addr),
    .wdata        (bus_wdata),
    .wr           (bus_wr),
    .rd           (bus_rd),
    .rdata        (bus_rdata),
    .en           (en),
    .pend         (pend),
    .act          (act),
    .prio_flat    (prio_flat),
    .pend_valid   (pwin.valid),
    .pend_id      (pwin.id),
    .act_valid    (awin.valid),
    .act_id       (awin.id),
    .act_prio     (awin.prio),
    .en_set       (en_set),
    .en_clr       (en_clr),
    .pd_set       (pd_set),
    .pd_clr       (pd_clr),
    .trig_valid   (trig_valid),
    .trig_id      (trig_id),
    .prio_word_we (prio_word_we)
  );

  irq_state_bank #(.NUM_LINES(NUM_LINES)) u_bank (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .en_set       (en_set),
    .en_clr       (en_clr),
    .pd_set       (pd_set),
    .pd_clr       (pd_clr),
    .req          (irq_req),
    .trig_valid   (trig_valid),
    .trig_id      (trig_id),
    .ack          (irq_ack),
    .win          (pwin),
    .done         (irq_done),
    .done_id      (irq_done_id),
    .prio_word_we (prio_word_we),
    .wdata        (bus_wdata),
    .en           (en),
    .pend         (pend),
    .act          (act),
    .prio_flat    (prio_flat)
  );

  irq_arbiter #(.NUM_LINES(NUM_LINES)) u_arb_pend (
    .cand      (pend & en),
    .prio_flat (prio_flat),
    .win       (pwin)
  );

  irq_arbiter #(.NUM_LINES(NUM_LINES)) u_arb_act (
    .cand      (act),
    .prio_flat (prio_flat),
    .win       (awin)
  );

  assign irq_valid = pwin.valid;
  assign irq_id    = pwin.id;
  assign irq_prio  = pwin.prio;

  // R7: the presented line is always both pending and enabled
  p_winner_qualified_r7: assert property (@(posedge clk) disable iff (!rst_core_n)
    irq_valid |-> (en[irq_id] && pend[irq_id]));

  // R6: no winner is presented while nothing is pending and enabled
  p_no_spurious_r6: assert property (@(posedge clk) disable iff (!rst_core_n)
    ((pend & en) == '0) |-> !irq_valid);
endmodule

// File: tb/tb_irq_prio_ctrl.sv
`timescale 1ns/1ps
module tb_irq_prio_ctrl;
  localparam int NL = 64;
  localparam int NW = NL / 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [11:0]   bus_addr;
  logic [31:0]   bus_wdata;
  logic          bus_wr, bus_rd;
  logic [31:0]   bus_rdata;
  logic [NL-1:0] irq_req;
  logic          irq_ack, irq_done;
  logic [8:0]    irq_done_id;
  logic          irq_valid;
  logic [8:0]    irq_id;
  logic [7:0]    irq_prio;

  int n_tests = 0;
  int n_fail  = 0;

  logic [NL-1:0] m_en, m_pd, m_act;
  logic [7:0]    m_pr [NL];

  always #2.5 clk = ~clk;

  irq_prio_ctrl #(.NUM_LINES(NL)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq_req(irq_req),
    .irq_ack(irq_ack), .irq_done(irq_done), .irq_done_id(irq_done_id),
    .irq_valid(irq_valid), .irq_id(irq_id), .irq_prio(irq_prio)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rdchk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    chk(tag, bus_rdata, exp);
  endtask

  function automatic logic [7:0] pr_of(input int n);
    return 8'((n * 37 + 11) % 256);
  endfunction

  task automatic chk_words(input string tag);
    for (int w = 0; w < NW; w++) begin
      rdchk({tag, " en set view"},  12'(12'h100 + 4*w), m_en[w*32 +: 32]);
      rdchk({tag, " en clr view"},  12'(12'h140 + 4*w), m_en[w*32 +: 32]);
      rdchk({tag, " pd set view"},  12'(12'h180 + 4*w), m_pd[w*32 +: 32]);
      rdchk({tag, " pd clr view"},  12'(12'h1C0 + 4*w), m_pd[w*32 +: 32]);
      rdchk({tag, " active view"},  12'(12'h200 + 4*w), m_act[w*32 +: 32]);
    end
  endtask

  task automatic chk_arb(input string tag);
    logic v, av;
    int id, aid, cnt;
    logic [7:0] bp, ap;
    logic [31:0] st;
    v = 1'b0; av = 1'b0; id = 0; aid = 0; bp = 0; ap = 0; cnt = 0;
    for (int i = 0; i < NL; i++) begin
      if (m_en[i] && m_pd[i] && (!v || m_pr[i] < bp)) begin v = 1'b1; id = i; bp = m_pr[i]; end
      if (m_act[i] && (!av || m_pr[i] < ap)) begin av = 1'b1; aid = i; ap = m_pr[i]; end
      if (m_act[i]) cnt++;
    end
    @(negedge clk);
    chk({tag, " R6 valid"}, {31'b0, irq_valid}, {31'b0, v});
    if (v) begin
      chk({tag, " R6 id"},   {23'b0, irq_id},   32'(id));
      chk({tag, " R6 prio"}, {24'b0, irq_prio}, {24'b0, bp});
    end
    st = '0;
    st[9:0]   = v ? 10'(id + 16) : 10'd0;
    st[10]    = v;
    st[20:12] = av ? 9'(aid + 16) : 9'd0;
    st[21]    = (cnt <= 1);
    st[31:24] = av ? ap : 8'd0;
    rdchk({tag, " R12 status"}, 12'h004, st);
  endtask

  task automatic set_state(input logic [NL-1:0] en_v, input logic [NL-1:0] pd_v);
    for (int w = 0; w < NW; w++) begin
      wr(12'(12'h140 + 4*w), 32'hFFFF_FFFF);
      wr(12'(12'h100 + 4*w), en_v[w*32 +: 32]);
      wr(12'(12'h1C0 + 4*w), 32'hFFFF_FFFF);
      wr(12'(12'h180 + 4*w), pd_v[w*32 +: 32]);
    end
    m_en = en_v; m_pd = pd_v;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_wr = 1'b0; bus_rd = 1'b0;
    irq_req = '0; irq_ack = 1'b0; irq_done = 1'b0; irq_done_id = '0;
    m_en = '0; m_pd = '0; m_act = '0;
    for (int i = 0; i < NL; i++) m_pr[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state, R11 type word
    chk("R1 rdata after reset", bus_rdata, 32'h0);
    chk("R1 irq_valid after reset", {31'b0, irq_valid}, 32'h0);
    rdchk("R11 type word", 12'h000, 32'(NW - 1));
    chk_words("R1");
    for (int k = 0; k < NL/4; k++) rdchk("R1 prio word", 12'(12'h300 + 4*k), 32'h0);
    chk_arb("R1");

    // R2 enable set/clear sweep, one bit at a time
    for (int i = 0; i < NL; i++) begin
      wr(12'(12'h100 + 4*(i/32)), 32'h1 << (i % 32));
      m_en[i] = 1'b1;
      rdchk("R2 set one bit",   12'(12'h100 + 4*(i/32)), m_en[(i/32)*32 +: 32]);
      rdchk("R2 clr view read", 12'(12'h140 + 4*(i/32)), m_en[(i/32)*32 +: 32]);
    end
    for (int w = 0; w < NW; w++) begin
      wr(12'(12'h100 + 4*w), 32'h0);
      wr(12'(12'h140 + 4*w), 32'h0);
      rdchk("R2 zero writes no effect", 12'(12'h100 + 4*w), 32'hFFFF_FFFF);
      wr(12'(12'h140 + 4*w), 32'h5555_5555);
      m_en[w*32 +: 32] = 32'hAAAA_AAAA;
      rdchk("R2 clear pattern", 12'(12'h140 + 4*w), 32'hAAAA_AAAA);
    end

    // R5 priority byte packing sweep
    for (int k = 0; k < NL/4; k++) begin
      wr(12'(12'h300 + 4*k), {pr_of(4*k+3), pr_of(4*k+2), pr_of(4*k+1), pr_of(4*k)});
      for (int b = 0; b < 4; b++) m_pr[4*k+b] = pr_of(4*k+b);
    end
    for (int k = 0; k < NL/4; k++)
      rdchk("R5 prio readback", 12'(12'h300 + 4*k),
            {pr_of(4*k+3), pr_of(4*k+2), pr_of(4*k+1), pr_of(4*k)});

    // R3 pending set/clear views
    wr(12'h180, 32'hF0F0_00F0); wr(12'h184, 32'h8000_0001);
    m_pd[31:0] = 32'hF0F0_00F0; m_pd[63:32] = 32'h8000_0001;
    wr(12'h1C0, 32'h00F0_0030); m_pd[31:0] = 32'hF000_00C0;
    wr(12'h180, 32'h0);
    chk_words("R3");
    chk_arb("R7 half enabled");

    // R6 arbitration over several masks
    for (int t = 0; t < 8; t++) begin
      logic [NL-1:0] e, p;
      e = {32'(32'h9E37_79B9 * (t + 3)), 32'(32'h7F4A_7C15 * (t + 1))} | (t == 0 ? '1 : '0);
      p = {32'(32'hC2B2_AE35 * (t + 5)), 32'(32'h2545_F491 * (t + 2))};
      set_state(e, p);
      chk_arb("R6 pattern");
    end

    // R7 disabling the winner keeps its pending bit
    set_state('1, 64'h0000_0100_0000_0010);
    chk_arb("R7 before disable");
    wr(12'h140, 32'h0000_0010); m_en[4] = 1'b0;
    chk_arb("R7 after disable");
    rdchk("R7 pending kept", 12'h180, 32'h0000_0010);

    // R6 ties go to the lower line number
    wr(12'h308, 32'h0000_0000); for (int b = 8; b < 12; b++) m_pr[b] = 8'h00;
    wr(12'h328, 32'h0000_0000); for (int b = 40; b < 44; b++) m_pr[b] = 8'h00;
    set_state('1, 64'h0000_0200_0000_0300);
    chk_arb("R6 tie 8/9/41");

    // R4 request edges
    set_state('1, '0);
    @(negedge clk); irq_req[5] = 1'b1;
    @(negedge clk); m_pd[5] = 1'b1;
    rdchk("R4 edge pends", 12'h180, 32'h0000_0020);
    wr(12'h1C0, 32'h0000_0020); m_pd[5] = 1'b0;
    repeat (3) @(negedge clk);
    rdchk("R4 held level no repend", 12'h180, 32'h0);
    irq_req[5] = 1'b0;
    wr(12'h144, 32'h0000_0004); m_en[34] = 1'b0;
    @(negedge clk); irq_req[34] = 1'b1;
    repeat (2) @(negedge clk); irq_req[34] = 1'b0;
    rdchk("R4 disabled edge ignored", 12'h184, 32'h0);

    // R3 clear wins over a same-cycle hardware set
    @(negedge clk);
    irq_req[3] = 1'b1; bus_addr = 12'h1C0; bus_wdata = 32'h0000_0008; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    rdchk("R3 clear beats edge", 12'h180, 32'h0);
    irq_req[3] = 1'b0;

    // R8 acknowledge, R12 active fields
    set_state('1, 64'h0000_0400_0000_1200);
    chk_arb("R8 before ack");
    begin
      int w1;
      w1 = int'(irq_id);
      @(negedge clk); irq_ack = 1'b1;
      @(negedge clk); irq_ack = 1'b0;
      m_pd[w1] = 1'b0; m_act[w1] = 1'b1;
    end
    chk_words("R8 after ack");
    chk_arb("R12 one active");
    begin
      int w2;
      w2 = int'(irq_id);
      @(negedge clk); irq_ack = 1'b1;
      @(negedge clk); irq_ack = 1'b0;
      m_pd[w2] = 1'b0; m_act[w2] = 1'b1;
    end
    chk_arb("R12 two active");
    wr(12'h200, 32'hFFFF_FFFF); wr(12'h204, 32'hFFFF_FFFF);
    chk_words("R8 active read-only");

    // R9 completion by number
    for (int i = 0; i < NL; i++) begin
      if (m_act[i]) begin
        @(negedge clk); irq_done = 1'b1; irq_done_id = 9'(i);
        @(negedge clk); irq_done = 1'b0;
        m_act[i] = 1'b0;
        chk_words("R9 done clears");
        chk_arb("R9 status");
      end
    end

    // R10 software trigger
    set_state('1, '0);
    wr(12'h008, 32'd40); m_pd[40] = 1'b1;
    chk_words("R10 trigger 40");
    wr(12'h008, 32'd100);
    chk_words("R10 trigger out of range");
    chk_arb("R10 winner");

    // R13 unmapped and out-of-range reads
    rdchk("R13 unmapped", 12'h0FC, 32'h0);
    rdchk("R13 word index too large", 12'h148, 32'h0);
    rdchk("R13 misaligned", 12'h181, 32'h0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule